// File: doc/BRIEF.md
# Peripheral DMA Request Router with Interrupt Summary

This block sits between a set of peripheral DMA request lines and the request inputs of a bank of DMA channel engines. Every request line owns a small routing register that holds an enable flag and a destination channel number. When the flag is set, the line's level is forwarded to the request input of that channel. When several enabled lines point at the same channel, that channel sees the OR of their levels. The routing path is purely combinational from the stored routing state, so a routed request reaches its channel in the same cycle it rises.

The block also gathers the per-channel interrupt flags into one read-only summary word, so software can find all pending channels with a single read. A single combined interrupt output is raised while any channel flag is high. Software reaches the routing registers and the summary word through a simple register port with write and read strobes. Read data is registered: it appears one cycle after the read strobe and is held until the next read.

The register port is a control path with no back-pressure. Each strobe is taken in the cycle it is presented, and request and interrupt lines are level signals with no handshake.

Top module: `dreq_router`

## Requirements
- R1: After reset every routing register reads 0, `chan_req` is 0 for any `req_in` pattern, and `reg_rdata` is 0.
- R2: The routing register of request n (0 ≤ n < 64) sits at byte address 0x0100 + 4·n. For n ≥ 64 it sits at 0x1100 + 4·(n−64). On a read, bit 7 is the enable flag, bits 4:0 are the channel number, and all other bits are 0. A write stores wdata bit 7 and bits 4:0 and drops the rest.
- R3: A request line whose enable flag (bit 7) is clear drives no channel, whatever its channel field holds.
- R4: With the enable flag set and channel c stored, `chan_req[c]` follows that request line combinationally. A new routing takes effect from the clock edge that accepts the write.
- R5: When several enabled lines share one channel, that channel's request is the OR of those lines. Lines routed to different channels act independently.
- R6: Writing 0 to a routing register removes the line's routing, and the register then reads 0.
- R7: Address 0x00F0 reads the summary word. Bit i equals `chan_irq[i]` as sampled on the read edge. Writes to this address change nothing.
- R8: `irq_out` is high exactly when any bit of `chan_irq` is high.
- R9: A read and a write to the same routing register in one cycle return the register's previous content. Any address other than the routing registers and the summary word reads 0, and writes there change no routing.
- R10: `reg_rdata` is updated only on the clock edge after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 13 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| req_in | input | NUM_REQ (128) | Peripheral request levels |
| chan_irq | input | NUM_CHAN (32) | Per-channel interrupt flags |
| chan_req | output | NUM_CHAN (32) | Routed channel requests |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two functions can meet in one cycle. The first is a routing write landing while its request line is already high. The bench raises the line first, presents the write, and checks just after the accepting edge is still ahead that the channel output still shows the old routing. It then checks after the edge that the output shows the new one. The second is a read and a write aimed at the same routing register in the same cycle. The bench expects the read to return the old content and a following read to return the new content.

// File: rtl/dreq_router_pkg.sv
package dreq_router_pkg;
  localparam int MAX_REQ   = 128;
  localparam int REQ_IDX_W = 7;
  localparam int CH_FLD_W  = 5;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 13;

  localparam logic [ADDR_W-1:0] SUMMARY_ADDR = 13'h00F0;
  localparam logic [4:0]        LO_PAGE      = 5'h01;
  localparam logic [4:0]        HI_PAGE      = 5'h11;
  localparam int                VALID_BIT    = 7;

  typedef struct packed {
    logic                valid;
    logic [CH_FLD_W-1:0] chan;
  } route_ent_t;
endpackage

// File: rtl/dreq_map_bank.sv
module dreq_map_bank
  import dreq_router_pkg::*;
#(
  parameter int NUM_REQ  = 128,
  parameter int NUM_CHAN = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_CHAN-1:0]           irq_summary,
  output logic [DATA_W-1:0]             rdata,
  output logic [NUM_REQ-1:0]            ent_valid,
  output logic [NUM_REQ-1:0][CH_FLD_W-1:0] ent_chan
);
  route_ent_t ent_q [NUM_REQ];

  logic [REQ_IDX_W-1:0] idx;
  logic                 ent_hit;
  logic                 sum_hit;
  logic [DATA_W-1:0]    sum_word;
  logic [DATA_W-1:0]    rd_next;

  always_comb begin
    idx     = '0;
    ent_hit = 1'b0;
    if (addr[1:0] == 2'b00) begin
      if (addr[12:8] == LO_PAGE) begin
        idx     = {1'b0, addr[7:2]};
        ent_hit = (int'(idx) < NUM_REQ);
      end else if (addr[12:8] == HI_PAGE) begin
        idx     = {1'b1, addr[7:2]};
        ent_hit = (int'(idx) < NUM_REQ);
      end
    end
  end

  assign sum_hit = (addr == SUMMARY_ADDR);

  always_comb begin
    sum_word = '0;
    sum_word[NUM_CHAN-1:0] = irq_summary;
  end

  always_comb begin
    rd_next = '0;
    if (ent_hit) begin
      rd_next[VALID_BIT]       = ent_q[idx].valid;
      rd_next[CH_FLD_W-1:0]    = ent_q[idx].chan;
    end else if (sum_hit) begin
      rd_next = sum_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_REQ; n++) ent_q[n] <= '0;
    end else if (wr_en && ent_hit) begin
      ent_q[idx].valid <= wdata[VALID_BIT];
      ent_q[idx].chan  <= wdata[CH_FLD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  generate
    for (genvar n = 0; n < NUM_REQ; n++) begin : g_out
      assign ent_valid[n] = ent_q[n].valid;
      assign ent_chan[n]  = ent_q[n].chan;
    end
  endgenerate

  // checker state
  logic                 primed;
  logic [REQ_IDX_W-1:0] chk_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      chk_idx <= '0;
    end else begin
      primed  <= 1'b1;
      chk_idx <= idx;
    end
  end

  // R6: a zero write leaves the entry disabled
  a_r6_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ent_hit && wdata == '0) |=> !ent_q[chk_idx].valid);

  // R7: summary read returns the flags seen at the read edge
  a_r7_summary_read: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(rd_en && sum_hit)) |-> rdata == $past(sum_word));

  // R10: read data holds without a read strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(rd_en)) |-> $stable(rdata));
endmodule

// File: rtl/dreq_route_matrix.sv
module dreq_route_matrix
  import dreq_router_pkg::*;
#(
  parameter int NUM_REQ  = 128,
  parameter int NUM_CHAN = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REQ-1:0]               req_in,
  input  logic [NUM_REQ-1:0]               ent_valid,
  input  logic [NUM_REQ-1:0][CH_FLD_W-1:0] ent_chan,
  output logic [NUM_CHAN-1:0]              chan_req
);
  generate
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      logic hit_c;
      always_comb begin
        hit_c = 1'b0;
        for (int n = 0; n < NUM_REQ; n++) begin
          if (ent_valid[n] && (ent_chan[n] == CH_FLD_W'(c)))
            hit_c = hit_c | req_in[n];
        end
      end
      assign chan_req[c] = hit_c;
    end
  endgenerate

  // R3: no channel request can appear without some raised, enabled line
  a_r3_no_phantom_req: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req != '0) |-> ((req_in & ent_valid) != '0));

  // R5: with no enabled line raised, every channel is quiet
  a_r5_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_in & ent_valid) == '0) |-> (chan_req == '0));
endmodule

// File: rtl/dreq_irq_merge.sv
module dreq_irq_merge #(
  parameter int NUM_CHAN = 32
) (
  input  logic [NUM_CHAN-1:0] chan_irq,
  output logic [NUM_CHAN-1:0] irq_summary,
  output logic                irq_out
);
  assign irq_summary = chan_irq;
  assign irq_out     = |chan_irq;
endmodule

// File: rtl/dreq_router.sv
module dreq_router
  import dreq_router_pkg::*;
#(
  parameter int NUM_REQ  = 128,
  parameter int NUM_CHAN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [NUM_REQ-1:0]   req_in,
  input  logic [NUM_CHAN-1:0]  chan_irq,
  output logic [NUM_CHAN-1:0]  chan_req,
  output logic                 irq_out
);
  logic [NUM_REQ-1:0]               ent_valid;
  logic [NUM_REQ-1:0][CH_FLD_W-1:0] ent_chan;
  logic [NUM_CHAN-1:0]              irq_summary;

  dreq_irq_merge #(.NUM_CHAN(NUM_CHAN)) u_irq (
    .chan_irq    (chan_irq),
    .irq_summary (irq_summary),
    .irq_out     (irq_out)
  );

  dreq_map_bank #(.NUM_REQ(NUM_REQ), .NUM_CHAN(NUM_CHAN)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr_en),
    .rd_en       (reg_rd_en),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .irq_summary (irq_summary),
    .rdata       (reg_rdata),
    .ent_valid   (ent_valid),
    .ent_chan    (ent_chan)
  );

  dreq_route_matrix #(.NUM_REQ(NUM_REQ), .NUM_CHAN(NUM_CHAN)) u_matrix (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_in    (req_in),
    .ent_valid (ent_valid),
    .ent_chan  (ent_chan),
    .chan_req  (chan_req)
  );

  // R8: combined interrupt agrees with the summary seen by software
  a_r8_irq_matches_summary: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (irq_summary != '0));
endmodule

// File: tb/test_dreq_router.sv
module test_dreq_router;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr_en = 1'b0;
  logic         reg_rd_en = 1'b0;
  logic [12:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [127:0] req_in = '0;
  logic [31:0]  chan_irq = '0;
  logic [31:0]  chan_req;
  logic         irq_out;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dreq_router i_dreq_router (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_in(req_in), .chan_irq(chan_irq), .chan_req(chan_req), .irq_out(irq_out)
  );

  function automatic logic [12:0] map_addr(int n);
    if (n < 64) return 13'(32'h0100 + 4 * n);
    else        return 13'(32'h1100 + 4 * (n - 64));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    req_in = '1;
    #1;
    chk("R1 chan_req after reset", chan_req, 32'h0);
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    chk("R1 irq_out after reset", {31'h0, irq_out}, 32'h0);
    rd(map_addr(5), d);
    chk("R1 map 5 reads zero", d, 32'h0);
    rd(map_addr(127), d);
    chk("R1 map 127 reads zero", d, 32'h0);
    req_in = '0;
  endtask

  task automatic t_addressing();
    logic [31:0] d;
    wr(map_addr(3), 32'h0000_0085);
    rd(13'h010C, d);
    chk("R2 map 3 at 0x010C", d, 32'h85);
    wr(13'h1118, 32'hFFFF_FFFF);
    rd(map_addr(70), d);
    chk("R2 map 70 keeps only fields", d, 32'h9F);
  endtask

  task automatic t_route();
    req_in[3] = 1'b1; #1;
    chk("R4 line 3 to ch5", chan_req, 32'h0000_0020);
    req_in[3] = 1'b0; #1;
    chk("R4 line 3 low", chan_req, 32'h0);
    req_in[70] = 1'b1; #1;
    chk("R4 line 70 to ch31", chan_req, 32'h8000_0000);
    req_in[70] = 1'b0;
    // write landing while the line is already high
    req_in[40] = 1'b1;
    @(negedge clk);
    reg_addr = map_addr(40); reg_wdata = 32'h82; reg_wr_en = 1'b1;
    #1;
    chk("R4 old routing before edge", chan_req, 32'h0);
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk("R4 new routing after edge", chan_req, 32'h0000_0004);
    req_in[40] = 1'b0;
  endtask

  task automatic t_invalid();
    wr(map_addr(10), 32'h0000_0007);
    req_in[10] = 1'b1; #1;
    chk("R3 disabled line silent", chan_req, 32'h0);
    req_in[10] = 1'b0;
  endtask

  task automatic t_or();
    wr(map_addr(20), 32'h89);
    wr(map_addr(100), 32'h89);
    req_in[20] = 1'b1; req_in[100] = 1'b1; #1;
    chk("R5 both lines ch9", chan_req, 32'h0000_0200);
    req_in[20] = 1'b0; #1;
    chk("R5 one line ch9", chan_req, 32'h0000_0200);
    req_in[3] = 1'b1; #1;
    chk("R5 independent ch5 and ch9", chan_req, 32'h0000_0220);
    req_in[100] = 1'b0; req_in[3] = 1'b0; #1;
    chk("R5 none raised", chan_req, 32'h0);
  endtask

  task automatic t_unmap();
    logic [31:0] d;
    wr(map_addr(3), 32'h0);
    req_in[3] = 1'b1; #1;
    chk("R6 cleared line silent", chan_req, 32'h0);
    rd(map_addr(3), d);
    chk("R6 cleared map reads zero", d, 32'h0);
    req_in[3] = 1'b0;
  endtask

  task automatic t_summary();
    logic [31:0] d;
    chan_irq = 32'hA500_0011;
    rd(13'h00F0, d);
    chk("R7 summary read", d, 32'hA500_0011);
    wr(13'h00F0, 32'h0);
    rd(13'h00F0, d);
    chk("R7 summary write ignored", d, 32'hA500_0011);
    chan_irq = 32'h0; #1;
    chk("R8 irq_out low", {31'h0, irq_out}, 32'h0);
    chan_irq = 32'h8000_0000; #1;
    chk("R8 irq_out high", {31'h0, irq_out}, 32'h1);
    chan_irq = 32'h0;
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk);
    reg_addr = 13'h1100; reg_wdata = 32'h82; reg_wr_en = 1'b1; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_rd_en = 1'b0;
    chk("R9 same-cycle read gets old", reg_rdata, 32'h0);
    rd(13'h1100, d);
    chk("R9 later read gets new", d, 32'h82);
    wr(13'h00FC, 32'h81);
    rd(13'h00FC, d);
    chk("R9 unmapped address reads zero", d, 32'h0);
    rd(13'h1200, d);
    chk("R9 high unmapped reads zero", d, 32'h0);
    req_in = '0; req_in[64] = 1'b1; #1;
    chk("R9 unmapped write left routing", chan_req, 32'h0000_0004);
    req_in = '0;
  endtask

  task automatic t_hold();
    logic [31:0] d;
    rd(map_addr(100), d);
    chk("R10 read value", d, 32'h89);
    @(negedge clk);
    reg_addr = map_addr(0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 rdata held", reg_rdata, 32'h89);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addressing();
    t_route();
    t_invalid();
    t_or();
    t_unmap();
    t_summary();
    t_collide();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule